// File: doc/BRIEF.md
# Oscillator Configuration Mailbox Responder

This block is a slave register block on a simple 32-bit memory-mapped bus. It stands in for a board's system-configuration mailbox. Software loads a control word that names a target by domain, site, position, function and device number. When the word has its start bit set and asks for a read from the oscillator function, the block answers at once. It places the fixed clock frequency of the addressed device, in hertz, into its data register.

Software can also load and read the data register directly. The control register always reads as idle. The status register always reads as one. A read returns its data in the cycle after the request. Requests that the block does not service leave the data register as it was. Writes are one example, and so are other functions and sites with no oscillators.

Top module: `osccfg_responder`

## Requirements
- R1: After reset the data register holds 0, and `bus_rdata` is 0 until the first read.
- R2: A bus write to offset 0xA0 loads the data register with `bus_wdata`. A read of 0xA0 returns the register's current value on `bus_rdata` in the cycle after the request, and `bus_rdata` holds that value until the next read.
- R3: A read of the control offset 0xA4 returns 0. A read of the status offset 0xA8 returns 1.
- R4: A control word splits into these fields: device [11:0], position [15:12], site [17:16], function [25:20], domain [29:26], write flag [30] and start flag [31]. A control write with bit 31 at 0 leaves the data register unchanged.
- R5: A started control word with bit 30 at 1 has no effect on the data register.
- R6: A started read is serviced only when domain is 0, position is 0 and function is 1. Any other combination leaves the data register unchanged.
- R7: A serviced read of site 0 loads 25000000 for device 0, 25000000 for device 1 and 24000000 for device 2.
- R8: A serviced read of site 1 loads the following values: 50000000 for device 0, 40000000 for device 4, 50000000 for device 5, 35000000 for device 6, 40000000 for device 7 and 40000000 for device 8.
- R9: A serviced read of a device on site 0 or site 1 that has no listed frequency loads 0.
- R10: A serviced read that names site 2 or site 3 leaves the data register unchanged.
- R11: A read of any offset other than 0xA0, 0xA4 or 0xA8 returns 0. Writes to such offsets, or to 0xA8, change nothing that any later read can see.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the read request |

## Verification
Assertions check several rules on every cycle. The data register holds its value unless a write reaches the data or control offset. An unstarted control word, a write-flagged word, a word with the wrong function, and a word naming site 2 or 3 all leave it stable. Reads of the control, status and unmapped offsets return their fixed values. Only the bench's scenarios can show that each listed site and device yields its exact frequency, and that an unlisted device yields 0. The same holds for the reset value and for direct load and read-back of the data register.

// File: rtl/osccfg_pkg.sv
package osccfg_pkg;

   // which register a bus access selects
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_STAT = 2'd3
   } reg_sel_e;

   // request word layout, most significant field first
   typedef struct packed {
      logic       start;
      logic       wr_req;
      logic [3:0] domain;
      logic [5:0] func;
      logic [1:0] spare;
      logic [1:0] site;
      logic [3:0] pos;
      logic [11:0] dev;
   } req_word_t;

   localparam int REQ_W  = $bits(req_word_t);
   localparam int DEV_W  = 12;
   localparam int SITE_W = 2;

endpackage

// File: rtl/osccfg_decode.sv
module osccfg_decode
   import osccfg_pkg::*;
#(
   parameter int              ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] OFS_DATA = 8'hA0,
   parameter logic [ADDR_W-1:0] OFS_CTRL = 8'hA4,
   parameter logic [ADDR_W-1:0] OFS_STAT = 8'hA8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   generate
      if (OFS_DATA == OFS_CTRL || OFS_DATA == OFS_STAT || OFS_CTRL == OFS_STAT) begin : g_bad_ofs
         $error("osccfg_decode: register offsets must be distinct");
      end
      if (ADDR_W < 2) begin : g_bad_aw
         $error("osccfg_decode: address too narrow");
      end
   endgenerate

   always_comb begin
      sel = SEL_NONE;
      if (addr == OFS_DATA) sel = SEL_DATA;
      else if (addr == OFS_CTRL) sel = SEL_CTRL;
      else if (addr == OFS_STAT) sel = SEL_STAT;
   end

endmodule

// File: rtl/osccfg_reqsplit.sv
module osccfg_reqsplit
   import osccfg_pkg::*;
#(
   parameter logic [3:0] SVC_DOMAIN = 4'd0,
   parameter logic [3:0] SVC_POS    = 4'd0,
   parameter logic [5:0] SVC_FUNC   = 6'd1
) (
   input  logic [REQ_W-1:0]  word,
   output logic [SITE_W-1:0] site,
   output logic [DEV_W-1:0]  dev,
   output logic              svc_read
);

   req_word_t req;

   always_comb begin
      req      = req_word_t'(word);
      site     = req.site;
      dev      = req.dev;
      svc_read = req.start && !req.wr_req &&
                 (req.domain == SVC_DOMAIN) &&
                 (req.pos == SVC_POS) &&
                 (req.func == SVC_FUNC);
   end

endmodule

// File: rtl/osccfg_freqmap.sv
module osccfg_freqmap
   import osccfg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int N0     = 3,
   parameter int N1     = 6,
   parameter logic [DEV_W-1:0]  S0_DEV [N0] = '{12'd0, 12'd1, 12'd2},
   parameter logic [DATA_W-1:0] S0_HZ  [N0] = '{32'd25000000, 32'd25000000, 32'd24000000},
   parameter logic [DEV_W-1:0]  S1_DEV [N1] = '{12'd0, 12'd4, 12'd5, 12'd6, 12'd7, 12'd8},
   parameter logic [DATA_W-1:0] S1_HZ  [N1] = '{32'd50000000, 32'd40000000, 32'd50000000,
                                              32'd35000000, 32'd40000000, 32'd40000000}
) (
   input  logic [SITE_W-1:0] site,
   input  logic [DEV_W-1:0]  dev,
   output logic              site_ok,
   output logic [DATA_W-1:0] hz
);

   logic [N0-1:0] m0;
   logic [N1-1:0] m1;

   generate
      if (N0 < 1 || N1 < 1) begin : g_bad_n
         $error("osccfg_freqmap: each site needs at least one entry");
      end
      for (genvar i = 0; i < N0; i++) begin : g_s0
         assign m0[i] = (dev == S0_DEV[i]);
      end
      for (genvar j = 0; j < N1; j++) begin : g_s1
         assign m1[j] = (dev == S1_DEV[j]);
      end
   endgenerate

   always_comb begin
      site_ok = (site == 2'd0) || (site == 2'd1);
      hz      = '0;
      if (site == 2'd0) begin
         for (int i = 0; i < N0; i++)
            if (m0[i]) hz = S0_HZ[i];
      end else if (site == 2'd1) begin
         for (int j = 0; j < N1; j++)
            if (m1[j]) hz = S1_HZ[j];
      end
   end

endmodule

// File: rtl/osccfg_responder.sv
module osccfg_responder
   import osccfg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam logic [DATA_W-1:0] CTRL_RD = '0;
   localparam logic [DATA_W-1:0] STAT_RD = DATA_W'(1);

   generate
      if (DATA_W != REQ_W) begin : g_bad_dw
         $error("osccfg_responder: data width must equal request word width");
      end
   endgenerate

   reg_sel_e           sel;
   logic [SITE_W-1:0]  site;
   logic [DEV_W-1:0]   dev;
   logic               svc_read;
   logic               site_ok;
   logic [DATA_W-1:0]  hz;
   logic [DATA_W-1:0]  data_q;
   logic               wr_data, wr_ctrl, rd_any;

   osccfg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   osccfg_reqsplit u_split (
      .word     (bus_wdata),
      .site     (site),
      .dev      (dev),
      .svc_read (svc_read)
   );

   osccfg_freqmap #(.DATA_W(DATA_W)) u_map (
      .site    (site),
      .dev     (dev),
      .site_ok (site_ok),
      .hz      (hz)
   );

   assign wr_data = bus_valid && bus_write && (sel == SEL_DATA);
   assign wr_ctrl = bus_valid && bus_write && (sel == SEL_CTRL);
   assign rd_any  = bus_valid && !bus_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         data_q <= '0;
      else if (wr_data)
         data_q <= bus_wdata;
      else if (wr_ctrl && svc_read && site_ok)
         data_q <= hz;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (rd_any) begin
         case (sel)
            SEL_DATA: bus_rdata <= data_q;
            SEL_CTRL: bus_rdata <= CTRL_RD;
            SEL_STAT: bus_rdata <= STAT_RD;
            default:  bus_rdata <= '0;
         endcase
      end
   end

   AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> (data_q == $past(bus_wdata)));  // R2
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write && (sel == SEL_DATA || sel == SEL_CTRL)) |=> $stable(data_q));  // R11
   AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !bus_wdata[31]) |=> $stable(data_q));  // R4
   AST_WRITE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[30]) |=> $stable(data_q));  // R5
   AST_WRONG_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[25:20] != 6'd1) |=> $stable(data_q));  // R6
   AST_HIGH_SITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[17]) |=> $stable(data_q));  // R10
   AST_CTRL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && sel == SEL_CTRL) |=> (bus_rdata == '0));  // R3
   AST_STAT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && sel == SEL_STAT) |=> (bus_rdata == DATA_W'(1)));  // R3
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && sel == SEL_NONE) |=> (bus_rdata == '0));  // R11

endmodule

// File: tb/tb_osccfg_responder.sv
module tb_osccfg_responder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   osccfg_responder dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   localparam logic [31:0] PRE = 32'h1234_5678;
   localparam int NV = 20;
   localparam logic [31:0] V_CTL [NV] = '{
      32'h8010_0000, 32'h8010_0001, 32'h8010_0002,                // R7
      32'h8010_0003,                                              // R9
      32'h8011_0000, 32'h8011_0004, 32'h8011_0005,                // R8
      32'h8011_0006, 32'h8011_0007, 32'h8011_0008,                // R8
      32'h8011_0003, 32'h8011_0FFF,                               // R9
      32'h8012_0000, 32'h8013_0000,                               // R10
      32'h0010_0000,                                              // R4
      32'hC010_0000,                                              // R5
      32'h8410_0000, 32'h8010_1000, 32'h8020_0000, 32'h8000_0000  // R6
   };
   localparam logic [31:0] V_EXP [NV] = '{
      32'd25000000, 32'd25000000, 32'd24000000,
      32'd0,
      32'd50000000, 32'd40000000, 32'd50000000,
      32'd35000000, 32'd40000000, 32'd40000000,
      32'd0, 32'd0,
      PRE, PRE,
      PRE,
      PRE,
      PRE, PRE, PRE, PRE
   };
   localparam int V_REQ [NV] = '{7, 7, 7, 9, 8, 8, 8, 8, 8, 8, 9, 9,
                                 10, 10, 4, 5, 6, 6, 6, 6};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      chk("R1 rdata at reset", bus_rdata, 32'd0);
      rst_n = 1'b1;
      rd(8'hA0, v);
      chk("R1 data after reset", v, 32'd0);

      for (int i = 0; i < NV; i++) begin
         wr(8'hA0, PRE);
         wr(8'hA4, V_CTL[i]);
         rd(8'hA0, v);
         chk($sformatf("R%0d vector %0d", V_REQ[i], i), v, V_EXP[i]);
      end

      // R2 direct load, read-back and hold
      wr(8'hA0, 32'hA5A5_5A5A);
      rd(8'hA0, v);
      chk("R2 readback", v, 32'hA5A5_5A5A);
      repeat (3) @(negedge clk);
      chk("R2 rdata holds", bus_rdata, 32'hA5A5_5A5A);

      // R3 fixed registers, also right after a serviced request
      rd(8'hA4, v);
      chk("R3 ctrl reads 0", v, 32'd0);
      wr(8'hA4, 32'h8011_0000);
      rd(8'hA4, v);
      chk("R3 ctrl idle after request", v, 32'd0);
      rd(8'hA8, v);
      chk("R3 status reads 1", v, 32'd1);

      // R11 ignored writes and unmapped reads
      wr(8'hA0, 32'hCAFE_0001);
      wr(8'hA8, 32'hFFFF_FFFF);
      rd(8'hA8, v);
      chk("R11 status after write", v, 32'd1);
      wr(8'h10, 32'h0BAD_0BAD);
      wr(8'hA1, 32'h8010_0000);
      rd(8'hA0, v);
      chk("R11 data untouched", v, 32'hCAFE_0001);
      rd(8'h10, v);
      chk("R11 unmapped 0x10", v, 32'd0);
      rd(8'hA1, v);
      chk("R11 unmapped 0xA1", v, 32'd0);
      rd(8'hFC, v);
      chk("R11 unmapped 0xFC", v, 32'd0);

      // R1 reset mid-run clears the data register
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 rdata after second reset", bus_rdata, 32'd0);
      rst_n = 1'b1;
      rd(8'hA0, v);
      chk("R1 data after second reset", v, 32'd0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule